// File: doc/BRIEF.md
# Write-Protected Page Write Buffer

This block sits between a byte-level serial slave front end and a 128-byte storage array. The front end reports the events of a transaction: a word address that starts a new write, each received data byte, a stop, and an abort. During a write the block keeps up to sixteen data bytes in a small ring, together with the word address each byte is meant for. The address steps through an aligned 16-byte page and wraps inside it. When a stop follows at least one byte, the block raises `busy` for a fixed number of clock cycles. At the end of that interval it writes the retained bytes into the array.

A write of any length leaves only its newest sixteen bytes in effect, because each byte past the sixteenth replaces the oldest one held. A protect strap keeps the upper half of the array unchanged while it is high. Reads skip the buffer: each request returns the array byte at the current address and then steps the address across the whole array. While `busy` is high the front end is expected to withhold acknowledges, and the block ignores every request.

Top module: `wp_page_wbuf`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 00h, the current address is 00h and every array byte is 00h.
- R2: An `addr_load` pulse sets the current address to `addr_in` and discards any bytes already buffered. Those bytes are never written.
- R3: A write of any length commits only its newest 16 bytes. Each byte past the sixteenth replaces the oldest buffered byte.
- R4: Each buffered byte goes to the current address. The address then increments in bits [3:0] only, so it wraps within its aligned 16-byte page and bits [6:4] never change.
- R5: If `wp` is high at commit, buffered bytes whose address has bit 6 set (40h to 7Fh) are dropped, and bytes below 40h are still written. If `wp` is low, every buffered byte is written.
- R6: A stop that follows at least one buffered byte makes `busy` go high in the next cycle and stay high for exactly PROG_CYCLES cycles. The array takes the new bytes on the edge where `busy` falls.
- R7: A stop with no byte buffered, and any `abort`, commit nothing and leave `busy` low. `abort` also empties the buffer.
- R8: While `busy` is high, `addr_load`, `byte_valid`, `stop_seen`, `abort` and `rd_req` are ignored. The array, the address and `rd_data` do not change because of them.
- R9: A `rd_req` in a non-busy cycle puts the array byte at the current address on `rd_data` in the next cycle and increments the address, wrapping from 7Fh to 00h.
- R10: When several requests arrive in the same cycle, only the first of this order is taken: `abort`, `stop_seen`, `addr_load`, `byte_valid`, `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Starts a new write and loads the current address |
| addr_in | input | 7 | Word address taken with `addr_load` |
| byte_valid | input | 1 | A write data byte is present |
| byte_in | input | 8 | Write data byte |
| stop_seen | input | 1 | Stop condition; commits the buffer if it is not empty |
| abort | input | 1 | Abandons the write in progress |
| rd_req | input | 1 | Request for the next read byte |
| wp | input | 1 | Write-protect strap for the upper half of the array |
| busy | output | 1 | Programming interval in progress |
| rd_data | output | 8 | Byte returned by the last read request |

## Verification
The hardest situation to bring about is request traffic that arrives while the programming interval runs. A well-behaved front end never produces it, yet any slip would corrupt the array or the read address without notice. The bench holds every request input high for the whole busy window of one commit. It then checks that `rd_data` has not moved, that no second busy window starts, and that a full array dump still matches the model. The main sweep covers start addresses at page edges and in both halves, lengths below, at and above sixteen, and both strap levels. After each write the bench reads back all 128 bytes.

// File: rtl/wp_page_wbuf.sv
module wp_page_wbuf #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int BUF_DEPTH   = 16,
  parameter int PROG_CYCLES = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  input  logic          stop_seen,
  input  logic          abort,
  input  logic          rd_req,
  input  logic          wp,
  output logic          busy,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;
  localparam int PW    = $clog2(BUF_DEPTH);
  localparam int CW    = $clog2(BUF_DEPTH + 1);
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0] mem   [WORDS];
  logic [AW-1:0] slot_a[BUF_DEPTH];
  logic [DW-1:0] slot_d[BUF_DEPTH];
  logic [PW-1:0] head;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur_addr;
  logic [TW-1:0] tmr;
  logic          busy_q;
  logic [DW-1:0] rd_q;

  wire idle     = !busy_q;
  wire do_abort = idle && abort;
  wire do_stop  = idle && !abort && stop_seen;
  wire do_load  = idle && !abort && !stop_seen && addr_load;
  wire do_byte  = idle && !abort && !stop_seen && !addr_load && byte_valid;
  wire do_rd    = idle && !abort && !stop_seen && !addr_load && !byte_valid && rd_req;
  wire commit   = busy_q && (tmr == '0);

  wire [AW-1:0] page_next = {cur_addr[AW-1:PW], cur_addr[PW-1:0] + 1'b1};

  assign busy    = busy_q;
  assign rd_data = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tmr      <= '0;
      cnt      <= '0;
      head     <= '0;
      cur_addr <= '0;
      rd_q     <= '0;
    end else begin
      if (busy_q) begin
        if (tmr == '0) begin
          busy_q <= 1'b0;
          cnt    <= '0;
          head   <= '0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (do_abort) begin
        cnt  <= '0;
        head <= '0;
      end
      if (do_stop && cnt != '0) begin
        busy_q <= 1'b1;
        tmr    <= TW'(PROG_CYCLES - 1);
      end
      if (do_load) begin
        cur_addr <= addr_in;
        cnt      <= '0;
        head     <= '0;
      end
      if (do_byte) begin
        head     <= head + 1'b1;
        cur_addr <= page_next;
        if (cnt != CW'(BUF_DEPTH)) cnt <= cnt + 1'b1;
      end
      if (do_rd) begin
        rd_q     <= mem[cur_addr];
        cur_addr <= cur_addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_byte) begin
      slot_a[head] <= cur_addr;
      slot_d[head] <= byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int j = 0; j < BUF_DEPTH; j++)
        if (j < int'(cnt) && !(wp && slot_a[j][AW-1]))
          mem[slot_a[j]] <= slot_d[j];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BUF_DEPTH));                                             // R3
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    do_byte |=> cur_addr == {$past(cur_addr[AW-1:PW]), PW'($past(cur_addr[PW-1:0]) + 1'b1)}); // R4
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stop_seen && cnt != '0));                   // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && tmr != '0 |=> busy_q);                                    // R6
  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> cnt == '0);                                       // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop && cnt == '0 |=> !busy_q);                                  // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cur_addr) && $stable(rd_q));                     // R8
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd && cur_addr == '1 |=> cur_addr == '0);                        // R9
endmodule

// File: tb/wp_page_wbuf_test.sv
`timescale 1ns/1ps
module wp_page_wbuf_test;
  localparam int PROG = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0, byte_valid = 1'b0, stop_seen = 1'b0, abort = 1'b0, rd_req = 1'b0, wp = 1'b0;
  logic [6:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic       busy;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, salt = 0;
  logic [7:0] model[128];

  always #5 clk = ~clk;

  wp_page_wbuf #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .stop_seen(stop_seen),
    .abort(abort), .rd_req(rd_req), .wp(wp), .busy(busy), .rd_data(rd_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [7:0] dval(input int a, input int n, input int k, input int s);
    return 8'(a * 5 + n * 11 + k * 37 + s * 3 + 1);
  endfunction

  function automatic logic [6:0] paddr(input int a, input int k);
    return {3'(a >> 4), 4'((a + k) & 15)};
  endfunction

  task automatic pulse_load(input logic [6:0] a);
    addr_load = 1'b1; addr_in = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic send_bytes(input int a, input int n, input int s);
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1; byte_in = dval(a, n, k, s);
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic read_all;
    pulse_load(7'h00);
    for (int i = 0; i < 128; i++) begin
      rd_req = 1'b1;
      @(negedge clk);
      check(rd_data == model[i], "R1/R3/R4/R5/R9 array dump", rd_data, model[i]);
    end
    rd_req = 1'b0;
  endtask

  task automatic wr_txn(input int a, input int n, input bit poke);
    int b;
    logic [7:0] rd_before;
    salt++;
    pulse_load(7'(a));
    send_bytes(a, n, salt);
    rd_before = rd_data;
    stop_seen = 1'b1;
    @(negedge clk);
    stop_seen = 1'b0;
    b = 0;
    if (poke) begin
      addr_load = 1'b1; addr_in = 7'h05; byte_valid = 1'b1; byte_in = 8'hAA;
      rd_req = 1'b1; abort = 1'b1; stop_seen = 1'b1;
    end
    while (busy && b < 1000) begin
      b++;
      @(negedge clk);
    end
    addr_load = 1'b0; byte_valid = 1'b0; rd_req = 1'b0; abort = 1'b0; stop_seen = 1'b0;
    check(b == PROG, "R6 busy length", b, PROG);
    for (int k = (n > 16 ? n - 16 : 0); k < n; k++) begin
      logic [6:0] ad;
      ad = paddr(a, k);
      if (!(wp && ad[6])) model[ad] = dval(a, n, k, salt);
    end
    if (poke) begin
      check(rd_data == rd_before, "R8 rd_data held during busy", rd_data, rd_before);
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        check(busy == 1'b0, "R8 no second commit", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int starts[5] = '{'h00, 'h1E, 'h37, 'h45, 'h7A};
    int lens[5]   = '{1, 3, 16, 17, 35};
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    read_all();

    for (int w = 0; w < 2; w++) begin
      wp = 1'(w);
      foreach (starts[s])
        foreach (lens[l]) begin
          wr_txn(starts[s], lens[l], 1'b0);
          read_all();
        end
    end
    wp = 1'b0;

    // R2: earlier bytes discarded by a fresh address load
    pulse_load(7'h20);
    send_bytes('h20, 3, 99);
    wr_txn('h50, 2, 1'b0);
    read_all();

    // R7: abort, then a stop, commits nothing
    pulse_load(7'h30);
    send_bytes('h30, 4, 77);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(busy == 1'b0, "R7 no busy after abort", busy, 0);
      @(negedge clk);
    end
    // R7: empty write
    pulse_load(7'h31);
    stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
    check(busy == 1'b0, "R7 no busy after empty write", busy, 0);
    read_all();

    // R10: abort wins over a simultaneous byte and stop
    pulse_load(7'h60);
    send_bytes('h60, 2, 55);
    abort = 1'b1; stop_seen = 1'b1; byte_valid = 1'b1; byte_in = 8'h3C;
    @(negedge clk);
    abort = 1'b0; stop_seen = 1'b0; byte_valid = 1'b0;
    check(busy == 1'b0, "R10 abort has priority", busy, 0);
    read_all();

    // R8: every request held high through a busy window
    wp = 1'b1;
    wr_txn('h3C, 9, 1'b1);
    wp = 1'b0;
    read_all();

    // R9: read address wraps from 7Fh to 00h
    pulse_load(7'h7E);
    for (int i = 0; i < 4; i++) begin
      rd_req = 1'b1;
      @(negedge clk);
      check(rd_data == model[(126 + i) % 128], "R9 read wrap", rd_data, model[(126 + i) % 128]);
    end
    rd_req = 1'b0;

    summary();
    $finish;
  end
endmodule